// File: doc/BRIEF.md
# Wide Memory with 16-bit Register Bus Bridge

This block stores words of a configurable width at a configurable number of rows and makes them reachable from two sides. A native user port reads and writes whole words. A 16-bit host register bus reaches the same storage one 16-bit slice at a time. The wide word is striped across several parallel slice memories. Each slice occupies a window of `DEPTH` bus addresses above a base address, so the host sees the memory as a stack of 16-bit tables.

A mode parameter sets the transfer direction. The memory can be fully shared, filled by logic for the host to read, or filled by the host for logic to read. Sides without a right in the chosen mode are ignored. Every location reads as zero after reset.

Top module: `wide_mem_bridge`

## Requirements
- R1: The user word is split into ceil(WIDTH/16) slices. Slice 0 holds user bits [15:0], and slice i holds bits [16i+15:16i]. Slice i of user row a sits at bus address BASE + a + i*DEPTH.
- R2: The first floor(WIDTH/16) slices are 16 bits wide. When WIDTH is not a multiple of 16, the highest slice stores only WIDTH mod 16 bits. A bus read of that slice returns the stored bits with zeros above them, and a bus write to it keeps only its low bits.
- R3: After reset every row reads as zero on the user port and on the bus. `usr_rdata` is zero and `bus_rvalid` is low in the first cycle after reset.
- R4: A user write holds `usr_we` high for one cycle with a row and full-width data. All slices of that row are updated, and the next bus read of each slice address returns its part of the word.
- R5: `usr_rdata` shows the word at the row presented on `usr_addr` at the previous clock edge.
- R6: A `bus_rd` request to an address inside [BASE, BASE + DEPTH*slices) gives `bus_rvalid` high together with the slice data exactly one cycle later. A request outside that range gives no `bus_rvalid`, and `bus_rdata` is zero whenever `bus_rvalid` is low.
- R7: A bus write with `bus_wr` changes only the addressed slice of the addressed row. The other slices of that row keep their values.
- R8: With MODE = XFER_BIDIR, both sides can write and both sides can read.
- R9: With MODE = XFER_TO_HOST, the user side writes and the bus reads. Bus writes are ignored, and `usr_rdata` stays zero.
- R10: With MODE = XFER_TO_DEV, the bus writes and the user side reads. User writes are ignored, and bus reads never raise `bus_rvalid`.
- R11: When a user write and a bus write hit the same slice of the same row in the same cycle, the user data is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| usr_addr | input | AW = clog2(DEPTH) | User row address |
| usr_wdata | input | WIDTH | User write data |
| usr_we | input | 1 | User write enable, one cycle per write |
| usr_rdata | output | WIDTH | User read data, one cycle after the address |
| bus_addr | input | BUS_AW | Host bus address |
| bus_wdata | input | 16 | Host bus write data |
| bus_wr | input | 1 | Host bus write strobe |
| bus_rd | input | 1 | Host bus read strobe |
| bus_rdata | output | 16 | Host bus read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read response strobe, one cycle after an in-range request |

## Verification
Both read paths have one register of latency. `usr_rdata` reflects the row presented at the previous edge, and `bus_rvalid` with its data arrives on the edge after the request. The bench applies every stimulus just after a falling edge. It then samples results at the next falling edge, which is half a cycle after the single capturing rising edge. A write therefore lands on one rising edge, and a read issued afterwards is sampled one full cycle later. The three mode variants run side by side on shared inputs, so each ignored operation is observed at the ports of the variant that lacks the right.

// File: rtl/wmem_pkg.sv
package wmem_pkg;

    localparam int BUS_DW = 16;

    typedef enum logic [1:0] {
        XFER_BIDIR   = 2'd0,
        XFER_TO_HOST = 2'd1,
        XFER_TO_DEV  = 2'd2
    } xfer_mode_e;

    typedef struct packed {
        logic usr_wr;
        logic usr_rd;
        logic bus_wr;
        logic bus_rd;
    } port_rights_t;

    function automatic port_rights_t rights_of(xfer_mode_e m);
        port_rights_t r;
        case (m)
            XFER_TO_HOST: r = '{usr_wr: 1'b1, usr_rd: 1'b0, bus_wr: 1'b0, bus_rd: 1'b1};
            XFER_TO_DEV:  r = '{usr_wr: 1'b0, usr_rd: 1'b1, bus_wr: 1'b1, bus_rd: 1'b0};
            default:      r = '{usr_wr: 1'b1, usr_rd: 1'b1, bus_wr: 1'b1, bus_rd: 1'b1};
        endcase
        return r;
    endfunction

    function automatic int slice_count(int w);
        return (w + BUS_DW - 1) / BUS_DW;
    endfunction

    function automatic int slice_width(int w, int idx);
        return (idx < w / BUS_DW) ? BUS_DW : (w % BUS_DW);
    endfunction

    function automatic int bits_for(int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/wmem_addr_map.sv
module wmem_addr_map #(
    parameter int BUS_AW = 16,
    parameter int BASE   = 0,
    parameter int DEPTH  = 512,
    parameter int NS     = 2,
    localparam int AW    = wmem_pkg::bits_for(DEPTH),
    localparam int SELW  = wmem_pkg::bits_for(NS)
) (
    input  logic [BUS_AW-1:0] bus_addr,
    output logic              hit,
    output logic [SELW-1:0]   sel,
    output logic [AW-1:0]     row
);
    localparam int SPAN = DEPTH * NS;

    logic [BUS_AW-1:0] offset;

    assign offset = bus_addr - BUS_AW'(BASE);
    assign hit    = (32'(bus_addr) >= BASE) && (32'(bus_addr) < BASE + SPAN);

    // Pick the highest slice window whose start lies at or below the offset.
    always_comb begin
        sel = '0;
        row = AW'(offset);
        for (int i = 1; i < NS; i++) begin
            if (32'(offset) >= i * DEPTH) begin
                sel = SELW'(i);
                row = AW'(offset - BUS_AW'(i * DEPTH));
            end
        end
    end
endmodule

// File: rtl/wmem_slice.sv
module wmem_slice #(
    parameter int DW     = 16,
    parameter int DEPTH  = 512,
    parameter bit USR_WR = 1'b1,
    parameter bit USR_RD = 1'b1,
    parameter bit BUS_WR = 1'b1,
    localparam int AW    = wmem_pkg::bits_for(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] u_addr,
    input  logic [DW-1:0] u_wdata,
    input  logic          u_we,
    output logic [DW-1:0] u_rdata,
    input  logic [AW-1:0] b_row,
    input  logic [DW-1:0] b_wdata,
    input  logic          b_we,
    output logic [DW-1:0] b_rdata
);
    logic [DW-1:0]    store [DEPTH];
    logic [DEPTH-1:0] live;
    logic             u_do_wr;
    logic             b_do_wr;

    assign u_do_wr = USR_WR && u_we;
    assign b_do_wr = BUS_WR && b_we;

    // Bus write first, user write last: on a row collision the user wins.
    always_ff @(posedge clk) begin
        if (b_do_wr) store[b_row] <= b_wdata;
        if (u_do_wr) store[u_addr] <= u_wdata;
    end

    // A row that was never written since reset reads as zero.
    always_ff @(posedge clk) begin
        if (rst) begin
            live <= '0;
        end else begin
            if (b_do_wr) live[b_row] <= 1'b1;
            if (u_do_wr) live[u_addr] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            u_rdata <= '0;
            b_rdata <= '0;
        end else begin
            u_rdata <= (USR_RD && live[u_addr]) ? store[u_addr] : '0;
            b_rdata <= live[b_row] ? store[b_row] : '0;
        end
    end
endmodule

// File: rtl/wmem_bus_resp.sv
module wmem_bus_resp #(
    parameter int NS    = 2,
    localparam int SELW = wmem_pkg::bits_for(NS),
    localparam int DW   = wmem_pkg::BUS_DW
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rd_take,
    input  logic [SELW-1:0]  sel,
    input  logic [NS*DW-1:0] slice_q,
    output logic [DW-1:0]    rdata,
    output logic             rvalid
);
    logic [SELW-1:0] sel_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rvalid <= 1'b0;
            sel_q  <= '0;
        end else begin
            rvalid <= rd_take;
            if (rd_take) sel_q <= sel;
        end
    end

    assign rdata = rvalid ? slice_q[32'(sel_q) * DW +: DW] : '0;
endmodule

// File: rtl/wide_mem_bridge.sv
module wide_mem_bridge
    import wmem_pkg::*;
#(
    parameter int         WIDTH  = 23,
    parameter int         DEPTH  = 512,
    parameter int         BASE   = 0,
    parameter int         BUS_AW = 16,
    parameter xfer_mode_e MODE   = XFER_BIDIR,
    localparam int        AW     = bits_for(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [AW-1:0]     usr_addr,
    input  logic [WIDTH-1:0]  usr_wdata,
    input  logic              usr_we,
    output logic [WIDTH-1:0]  usr_rdata,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic [15:0]       bus_wdata,
    input  logic              bus_wr,
    input  logic              bus_rd,
    output logic [15:0]       bus_rdata,
    output logic              bus_rvalid
);
    localparam int           NS     = slice_count(WIDTH);
    localparam int           SELW   = bits_for(NS);
    localparam port_rights_t RIGHTS = rights_of(MODE);

    logic             hit;
    logic [SELW-1:0]  sel;
    logic [AW-1:0]    row;
    logic [NS*16-1:0] slice_q;

    wmem_addr_map #(
        .BUS_AW (BUS_AW),
        .BASE   (BASE),
        .DEPTH  (DEPTH),
        .NS     (NS)
    ) u_map (
        .bus_addr (bus_addr),
        .hit      (hit),
        .sel      (sel),
        .row      (row)
    );

    for (genvar i = 0; i < NS; i++) begin : g_slice
        localparam int SW = slice_width(WIDTH, i);
        logic [SW-1:0] u_rd;
        logic [SW-1:0] b_rd;
        logic          b_we;

        assign b_we = bus_wr && hit && (sel == SELW'(i));

        wmem_slice #(
            .DW     (SW),
            .DEPTH  (DEPTH),
            .USR_WR (RIGHTS.usr_wr),
            .USR_RD (RIGHTS.usr_rd),
            .BUS_WR (RIGHTS.bus_wr)
        ) u_slice (
            .clk     (clk),
            .rst     (rst),
            .u_addr  (usr_addr),
            .u_wdata (usr_wdata[i*16 +: SW]),
            .u_we    (usr_we),
            .u_rdata (u_rd),
            .b_row   (row),
            .b_wdata (bus_wdata[SW-1:0]),
            .b_we    (b_we),
            .b_rdata (b_rd)
        );

        assign usr_rdata[i*16 +: SW] = u_rd;
        assign slice_q[i*16 +: 16]   = 16'(b_rd);
    end

    wmem_bus_resp #(
        .NS (NS)
    ) u_resp (
        .clk     (clk),
        .rst     (rst),
        .rd_take (bus_rd && hit && RIGHTS.bus_rd),
        .sel     (sel),
        .slice_q (slice_q),
        .rdata   (bus_rdata),
        .rvalid  (bus_rvalid)
    );
endmodule

// File: rtl/wmem_checker.sv
module wmem_checker #(
    parameter int                   WIDTH  = 23,
    parameter int                   DEPTH  = 512,
    parameter int                   BASE   = 0,
    parameter int                   BUS_AW = 16,
    parameter wmem_pkg::xfer_mode_e MODE   = wmem_pkg::XFER_BIDIR
) (
    input logic              clk,
    input logic              rst,
    input logic [BUS_AW-1:0] bus_addr,
    input logic              bus_rd,
    input logic [15:0]       bus_rdata,
    input logic              bus_rvalid,
    input logic [WIDTH-1:0]  usr_rdata
);
    localparam int NS      = wmem_pkg::slice_count(WIDTH);
    localparam int LASTW   = wmem_pkg::slice_width(WIDTH, NS - 1);
    localparam int TOP_END = BASE + NS * DEPTH;
    localparam int LAST_LO = BASE + (NS - 1) * DEPTH;

    logic in_rng;
    logic in_last;
    assign in_rng  = (32'(bus_addr) >= BASE) && (32'(bus_addr) < TOP_END);
    assign in_last = (32'(bus_addr) >= LAST_LO) && (32'(bus_addr) < TOP_END);

    AST_RVALID_AFTER_REQ: assert property (@(posedge clk) disable iff (rst)
        bus_rvalid |-> $past(bus_rd)); // R6

    AST_NO_RESP_OUT_OF_RANGE: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && !in_rng) |=> !bus_rvalid); // R6

    AST_RDATA_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        !bus_rvalid |-> (bus_rdata == 16'h0)); // R6

    AST_LAST_SLICE_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
        (bus_rvalid && $past(in_last)) |-> ((32'(bus_rdata) >> LASTW) == 0)); // R2

    AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (usr_rdata == '0 && !bus_rvalid)); // R3

    AST_TO_HOST_USR_QUIET: assert property (@(posedge clk) disable iff (rst)
        (MODE == wmem_pkg::XFER_TO_HOST) |-> (usr_rdata == '0)); // R9

    AST_TO_DEV_BUS_QUIET: assert property (@(posedge clk) disable iff (rst)
        (MODE == wmem_pkg::XFER_TO_DEV) |-> !bus_rvalid); // R10
endmodule

bind wide_mem_bridge wmem_checker #(
    .WIDTH  (WIDTH),
    .DEPTH  (DEPTH),
    .BASE   (BASE),
    .BUS_AW (BUS_AW),
    .MODE   (MODE)
) u_wmem_checker (
    .clk        (clk),
    .rst        (rst),
    .bus_addr   (bus_addr),
    .bus_rd     (bus_rd),
    .bus_rdata  (bus_rdata),
    .bus_rvalid (bus_rvalid),
    .usr_rdata  (usr_rdata)
);

// File: tb/test_wide_mem_bridge.sv
module test_wide_mem_bridge;
    import wmem_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int W    = 23;
    localparam int D    = 512;
    localparam int BASE = 'h100;
    localparam int AW   = 9;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] usr_addr = '0;
    logic [W-1:0]  usr_wdata = '0;
    logic          usr_we = 1'b0;
    logic [15:0]   bus_addr = '0;
    logic [15:0]   bus_wdata = '0;
    logic          bus_wr = 1'b0;
    logic          bus_rd = 1'b0;

    logic [W-1:0] ur_bi, ur_th, ur_td;
    logic [15:0]  rd_bi, rd_th, rd_td;
    logic         rv_bi, rv_th, rv_td;

    int errors = 0;
    int checks = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    wide_mem_bridge #(.WIDTH(W), .DEPTH(D), .BASE(BASE), .MODE(XFER_BIDIR)) i_wide_mem_bridge (
        .clk(clk), .rst(rst), .usr_addr(usr_addr), .usr_wdata(usr_wdata), .usr_we(usr_we),
        .usr_rdata(ur_bi), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_rdata(rd_bi), .bus_rvalid(rv_bi));

    wide_mem_bridge #(.WIDTH(W), .DEPTH(D), .BASE(BASE), .MODE(XFER_TO_HOST)) i_wide_mem_bridge_th (
        .clk(clk), .rst(rst), .usr_addr(usr_addr), .usr_wdata(usr_wdata), .usr_we(usr_we),
        .usr_rdata(ur_th), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_rdata(rd_th), .bus_rvalid(rv_th));

    wide_mem_bridge #(.WIDTH(W), .DEPTH(D), .BASE(BASE), .MODE(XFER_TO_DEV)) i_wide_mem_bridge_td (
        .clk(clk), .rst(rst), .usr_addr(usr_addr), .usr_wdata(usr_wdata), .usr_we(usr_we),
        .usr_rdata(ur_td), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_rdata(rd_td), .bus_rvalid(rv_td));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic usr_write(input int a, input logic [W-1:0] d);
        @(negedge clk);
        usr_addr = AW'(a); usr_wdata = d; usr_we = 1'b1;
        @(negedge clk);
        usr_we = 1'b0;
    endtask

    task automatic usr_read(input int a);
        @(negedge clk);
        usr_addr = AW'(a); usr_we = 1'b0;
        @(negedge clk);
        ur_bi_s = ur_bi; ur_th_s = ur_th; ur_td_s = ur_td;
    endtask

    task automatic bus_write(input int a, input logic [15:0] d);
        @(negedge clk);
        bus_addr = 16'(a); bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input int a);
        @(negedge clk);
        bus_addr = 16'(a); bus_rd = 1'b1;
        @(negedge clk);
        rd_bi_s = rd_bi; rv_bi_s = rv_bi; rd_th_s = rd_th; rv_th_s = rv_th;
        rd_td_s = rd_td; rv_td_s = rv_td;
        bus_rd = 1'b0;
    endtask

    logic [W-1:0] ur_bi_s, ur_th_s, ur_td_s;
    logic [15:0]  rd_bi_s, rd_th_s, rd_td_s;
    logic         rv_bi_s, rv_th_s, rv_td_s;

    task automatic t_reset_state();
        chk("R3 usr_rdata after reset", 32'(ur_bi), 0);
        chk("R3 bus_rvalid after reset", 32'(rv_bi), 0);
        bus_read(BASE);
        chk("R6 rvalid first row", 32'(rv_bi_s), 1);
        chk("R3 bus zero first row", 32'(rd_bi_s), 0);
        bus_read(BASE + 2 * D - 1);
        chk("R6 rvalid last address", 32'(rv_bi_s), 1);
        chk("R3 bus zero last address", 32'(rd_bi_s), 0);
        usr_read(7);
        chk("R3 user zero row 7", 32'(ur_bi_s), 0);
    endtask

    task automatic t_user_to_bus();
        usr_write(5, 23'h5ABCD);
        bus_read(BASE + 5);
        chk("R1 R4 slice0 row5", 32'(rd_bi_s), 32'hABCD);
        bus_read(BASE + 5 + D);
        chk("R1 R4 slice1 row5", 32'(rd_bi_s), 32'h0005);
        usr_write(D - 1, 23'h7FFFFF);
        bus_read(BASE + D - 1);
        chk("R4 slice0 top row", 32'(rd_bi_s), 32'hFFFF);
        bus_read(BASE + 2 * D - 1);
        chk("R2 narrow slice top row", 32'(rd_bi_s), 32'h007F);
        usr_read(5);
        chk("R5 user read row5", 32'(ur_bi_s), 32'h5ABCD);
    endtask

    task automatic t_bus_write();
        bus_write(BASE + 5 + D, 16'hFFFF);
        bus_read(BASE + 5 + D);
        chk("R2 narrow slice keeps 7 bits", 32'(rd_bi_s), 32'h007F);
        usr_read(5);
        chk("R7 R8 other slice kept", 32'(ur_bi_s), 32'h7FABCD);
        bus_write(BASE + 12, 16'h2468);
        usr_read(12);
        chk("R8 bus write seen by user", 32'(ur_bi_s), 32'h002468);
    endtask

    task automatic t_out_of_range();
        bus_read(BASE - 1);
        chk("R6 below range no rvalid", 32'(rv_bi_s), 0);
        chk("R6 below range data zero", 32'(rd_bi_s), 0);
        bus_read(BASE + 2 * D);
        chk("R6 above range no rvalid", 32'(rv_bi_s), 0);
    endtask

    task automatic t_collision();
        @(negedge clk);
        usr_addr = AW'(9); usr_wdata = 23'h123456; usr_we = 1'b1;
        bus_addr = 16'(BASE + 9); bus_wdata = 16'h1111; bus_wr = 1'b1;
        @(negedge clk);
        usr_we = 1'b0; bus_wr = 1'b0;
        bus_read(BASE + 9);
        chk("R11 user wins slice0", 32'(rd_bi_s), 32'h3456);
        bus_read(BASE + 9 + D);
        chk("R11 slice1 user data", 32'(rd_bi_s), 32'h0012);
    endtask

    task automatic t_modes();
        usr_write(3, 23'h400001);
        bus_read(BASE + 3);
        chk("R9 to-host bus reads user data", 32'(rd_th_s), 32'h0001);
        chk("R9 to-host rvalid", 32'(rv_th_s), 1);
        bus_read(BASE + 3 + D);
        chk("R9 to-host slice1", 32'(rd_th_s), 32'h0040);
        bus_write(BASE + 4, 16'hBEEF);
        bus_read(BASE + 4);
        chk("R9 to-host bus write ignored", 32'(rd_th_s), 0);
        usr_read(3);
        chk("R9 to-host usr_rdata zero", 32'(ur_th_s), 0);
        bus_write(BASE + 6, 16'h1234);
        usr_read(6);
        chk("R10 to-dev user reads bus data", 32'(ur_td_s), 32'h001234);
        usr_write(6, 23'h7FFFFF);
        usr_read(6);
        chk("R10 to-dev user write ignored", 32'(ur_td_s), 32'h001234);
        chk("R8 bidir user write taken", 32'(ur_bi_s), 32'h7FFFFF);
        bus_read(BASE + 6);
        chk("R10 to-dev no rvalid", 32'(rv_td_s), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset_state();
        t_user_to_bus();
        t_bus_write();
        t_out_of_range();
        t_collision();
        t_modes();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule